// File: doc/BRIEF.md
# Key-Protected Memory Controller Register File

This block is the 32-bit register bank that sits in front of an SDRAM controller's configuration logic. A host reaches it over a simple word-addressed bus covering a 4 KB window: a valid strobe, a write enable, a word index, 32-bit write data and 32-bit read data. Reads are answered in the same cycle as the strobe. Writes land on the next rising clock edge.

The register at index 0 is a lock. Writing the 32-bit unlock key stores a 1 there. Writing any other value stores a 0. While it holds 0, every write to another register is dropped and a one-cycle error pulse is raised. Several registers reshape the data written to them before storing it. The configuration word has read-only and hardware-forced fields, including a DRAM-size code taken from the RAM-size parameter. A PHY status word never reports busy. A self-test word always reports a finished, passing test. A parameter selects one of three controller generations. The generation changes the size encoding, the version field and the forced bits.

The RAM-size parameter must be one of the four legal sizes for the chosen generation. Any other value stops elaboration with an error.

Top module: `memctl_keyreg`

## Requirements
- R1: After reset the lock register (index 0) reads 0. The configuration register (index 1) reads only its forced fields, as if 0 had been written to it. Every other register, including indices 24 and 28, reads 0.
- R2: A write to index 0 stores 1 when the data is 0xFC600309 and stores 0 for any other value. Index 0 reads back 1 when unlocked and 0 when locked. A write to index 0 never raises the error pulse.
- R3: While locked, a write to any in-range index other than 0 leaves the stored value unchanged. `lock_err` is then high for exactly the one cycle after the write edge, and low otherwise.
- R4: Configuration bits 1:0 always hold the size code. The size code is 0, 1, 2 or 3 for RAM sizes of base, 2×base, 4×base and 8×base MB. The base is 64 MB for generation 1, 128 MB for generation 2 and 256 MB for generation 3.
- R5: On generation 1, configuration bits 31:11 and 3:2 read 0 and bit 6 reads 1. Bits 10:7 and 5:4 store the written data.
- R6: On generations 2 and 3, configuration bits 31:28 read the version code (1 and 3 respectively). Bits 3:2 read 3. Bits 18:14 and bit 6 read 0. Bit 19 reads 1 on generation 2 and 0 on generation 3. Bits 27:20, 13:7 and 5:4 store the written data.
- R7: On generations 2 and 3, a write to index 24 stores bit 0 as 0. Generation 3 also stores bit 4 as 1. Generation 1 stores the data unchanged.
- R8: On generations 2 and 3, a write to index 28 stores bit 12 as 1 and bit 13 as 0. Generation 1 stores the data unchanged.
- R9: Every other in-range register stores the written data unchanged. A read in the cycle right after a write returns the new value.
- R10: A read of an index at or above NUM_REGS returns 0. A write to such an index is discarded, does not alias onto a lower register, and raises no error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index (byte offset shifted right by two) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the strobe |
| lock_err | output | 1 | Pulse after a write refused by the lock |

## Verification
The bench builds three instances side by side on one shared bus, one per generation:
- Generation 1 with 512 MB, which gives the highest size code.
- Generation 2 with 128 MB, which gives the lowest size code.
- Generation 3 with 1024 MB, which gives an intermediate code.

Each access is therefore checked against all three masking rules at once. NUM_REGS keeps its default of 32. An index of 40 shares its low five bits with index 8, so the bench can check that out-of-range writes do not alias onto index 8. Each write pattern (all ones, all zeros and alternating bits) is read back through every instance, which covers both the forced-to-one and the forced-to-zero fields.

// File: rtl/memctl_keyreg_pkg.sv
package memctl_keyreg_pkg;

  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int IDX_LOCK = 0;
  localparam int IDX_CFG  = 1;
  localparam int IDX_PHY  = 24;
  localparam int IDX_TEST = 28;

  // smallest legal RAM size in MB for a generation
  function automatic int base_mb(input int gen);
    case (gen)
      1:       return 64;
      2:       return 128;
      default: return 256;
    endcase
  endfunction

  function automatic bit size_legal(input int gen, input int mb);
    bit ok;
    ok = 1'b0;
    for (int i = 0; i < 4; i++)
      if (mb == (base_mb(gen) << i)) ok = 1'b1;
    return ok && gen >= 1 && gen <= 3;
  endfunction

  function automatic logic [1:0] size_code(input int gen, input int mb);
    logic [1:0] c;
    c = 2'd0;
    for (int i = 0; i < 4; i++)
      if (mb == (base_mb(gen) << i)) c = 2'(i);
    return c;
  endfunction

  // bits a host can never change in the configuration word (size bits included)
  function automatic logic [WORD_W-1:0] cfg_ro_mask(input int gen);
    logic [WORD_W-1:0] m;
    m = 32'h0000_004F;                 // bit 6, bits 3:2, bits 1:0
    if (gen == 1) m |= 32'hFFFF_F800;  // 31:11
    else          m |= 32'hF00F_C000;  // 31:28, 19, 18:14
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_fixed(input int gen, input logic [1:0] code);
    logic [WORD_W-1:0] f;
    f = {30'd0, code};
    if (gen == 1) begin
      f[6] = 1'b1;
    end else begin
      f[31:28] = (gen == 2) ? 4'd1 : 4'd3;
      f[3:2]   = 2'b11;
      f[19]    = (gen == 2);
    end
    return f;
  endfunction

  function automatic logic [WORD_W-1:0] shape_word(input int gen, input int idx,
                                                   input logic [WORD_W-1:0] d,
                                                   input logic [1:0] code);
    logic [WORD_W-1:0] r;
    r = d;
    if (idx == IDX_CFG) begin
      r = (d & ~cfg_ro_mask(gen)) | cfg_fixed(gen, code);
    end else if (idx == IDX_PHY && gen >= 2) begin
      r[0] = 1'b0;
      if (gen == 3) r[4] = 1'b1;
    end else if (idx == IDX_TEST && gen >= 2) begin
      r[12] = 1'b1;
      r[13] = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/memctl_key_gate.sv
module memctl_key_gate
  import memctl_keyreg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic              unlocked,
  output logic              wr_allow,
  output logic              lock_err
);

  logic lock_hit;
  logic refused;

  assign lock_hit = wr_fire && in_range && (idx == IDX_W'(IDX_LOCK));
  assign refused  = wr_fire && in_range && !lock_hit && !unlocked;
  assign wr_allow = wr_fire && in_range && !lock_hit && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      lock_err <= 1'b0;
    end else begin
      if (lock_hit) unlocked <= (wdata == UNLOCK_KEY);
      lock_err <= refused;
    end
  end

endmodule

// File: rtl/memctl_reg_bank.sv
module memctl_reg_bank
  import memctl_keyreg_pkg::*;
#(
  parameter int         GEN      = 2,
  parameter int         NUM_REGS = 32,
  parameter logic [1:0] CODE     = 2'd0,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_allow,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q [NUM_REGS]
);

  assign word_q[0] = '0;   // index 0 lives in the key gate

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    localparam logic [WORD_W-1:0] RST_VAL =
      (i == IDX_CFG) ? cfg_fixed(GEN, CODE) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[i] <= RST_VAL;
      else if (wr_allow && idx == IDX_W'(i))
        word_q[i] <= shape_word(GEN, i, wdata, CODE);
    end
  end

endmodule

// File: rtl/memctl_rd_mux.sv
module memctl_rd_mux
  import memctl_keyreg_pkg::*;
#(
  parameter int  NUM_REGS = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic              unlocked,
  input  logic [WORD_W-1:0] word_q [NUM_REGS],
  output logic [WORD_W-1:0] rdata
);

  always_comb begin
    if (!in_range)                     rdata = '0;
    else if (idx == IDX_W'(IDX_LOCK))  rdata = {{(WORD_W-1){1'b0}}, unlocked};
    else                               rdata = word_q[idx];
  end

endmodule

// File: rtl/memctl_keyreg.sv
module memctl_keyreg
  import memctl_keyreg_pkg::*;
#(
  parameter int GEN      = 2,
  parameter int RAM_MB   = 512,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              lock_err
);

  localparam int                IDX_W = $clog2(NUM_REGS);
  localparam logic [1:0]        CODE  = size_code(GEN, RAM_MB);
  localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(NUM_REGS - 1);

  if (!size_legal(GEN, RAM_MB)) begin : g_bad_size
    $error("memctl_keyreg: RAM_MB not legal for this generation");
  end
  if (NUM_REGS <= IDX_TEST || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
    $error("memctl_keyreg: NUM_REGS out of range");
  end

  // named internal events, also used by the bound checker
  logic              wr_fire;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic              unlocked;
  logic              wr_allow;
  logic [WORD_W-1:0] word_q [NUM_REGS];
  logic [WORD_W-1:0] cfg_word;
  logic [WORD_W-1:0] phy_word;
  logic [WORD_W-1:0] test_word;

  assign wr_fire   = bus_valid && bus_we;
  assign in_range  = (bus_addr <= LAST);
  assign idx       = bus_addr[IDX_W-1:0];
  assign cfg_word  = word_q[IDX_CFG];
  assign phy_word  = word_q[IDX_PHY];
  assign test_word = word_q[IDX_TEST];

  memctl_key_gate #(.IDX_W(IDX_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .in_range (in_range),
    .idx      (idx),
    .wdata    (bus_wdata),
    .unlocked (unlocked),
    .wr_allow (wr_allow),
    .lock_err (lock_err)
  );

  memctl_reg_bank #(.GEN(GEN), .NUM_REGS(NUM_REGS), .CODE(CODE)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_allow (wr_allow),
    .idx      (idx),
    .wdata    (bus_wdata),
    .word_q   (word_q)
  );

  memctl_rd_mux #(.NUM_REGS(NUM_REGS)) u_rd (
    .in_range (in_range),
    .idx      (idx),
    .unlocked (unlocked),
    .word_q   (word_q),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/memctl_keyreg_chk.sv
module memctl_keyreg_chk
  import memctl_keyreg_pkg::*;
#(
  parameter int GEN      = 2,
  parameter int RAM_MB   = 512,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              lock_err,
  input logic              unlocked,
  input logic              wr_fire,
  input logic [31:0]       cfg_word,
  input logic [31:0]       phy_word,
  input logic [31:0]       test_word
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);
  localparam logic [1:0]        CODE = size_code(GEN, RAM_MB);

  logic refused_wr;
  assign refused_wr = wr_fire && !unlocked && bus_addr != '0 && bus_addr <= LAST;

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == '0) |=> (unlocked == $past(bus_wdata == UNLOCK_KEY)));

  // R3
  lock_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused_wr |=> lock_err);

  // R3
  lock_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> $past(refused_wr));

  // R3
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refused_wr |=> ($stable(cfg_word) && $stable(phy_word) && $stable(test_word)));

  // R4
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == ADDR_W'(IDX_CFG)) |=> (cfg_word[1:0] == CODE));

  // R7
  phy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GEN >= 2 && wr_fire && unlocked && bus_addr == ADDR_W'(IDX_PHY))
      |=> (!phy_word[0] && (GEN != 3 || phy_word[4])));

  // R8
  test_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GEN >= 2 && wr_fire && unlocked && bus_addr == ADDR_W'(IDX_TEST))
      |=> (test_word[12] && !test_word[13]));

  // R10
  range_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_we && bus_addr > LAST) |-> (bus_rdata == '0));

  // R10
  range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr > LAST) |=> (!lock_err && $stable(cfg_word)));

endmodule

bind memctl_keyreg memctl_keyreg_chk #(
  .GEN(GEN), .RAM_MB(RAM_MB), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .lock_err  (lock_err),
  .unlocked  (unlocked),
  .wr_fire   (wr_fire),
  .cfg_word  (cfg_word),
  .phy_word  (phy_word),
  .test_word (test_word)
);

// File: tb/memctl_keyreg_bench.sv
`timescale 1ns/1ps
module memctl_keyreg_bench;

  localparam int ADDR_W = 10;
  localparam int NG     = 3;
  localparam int RAMS [NG] = '{512, 128, 1024};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       rd  [NG];
  logic              err [NG];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  for (genvar g = 0; g < NG; g++) begin : g_dut
    memctl_keyreg #(.GEN(g + 1), .RAM_MB(RAMS[g])) u_memctl_keyreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (rd[g]),
      .lock_err  (err[g])
    );
  end

  // ---------------- expected-value model ----------------
  function automatic logic [31:0] exp_cfg(input int gen, input int ram_mb, input logic [31:0] d);
    logic [1:0] c;
    case (ram_mb >> (gen + 5))
      1:       c = 2'd0;
      2:       c = 2'd1;
      4:       c = 2'd2;
      default: c = 2'd3;
    endcase
    if (gen == 1)
      return {21'd0, d[10:7], 1'b1, d[5:4], 2'b00, c};
    return {(gen == 2) ? 4'd1 : 4'd3, d[27:20], (gen == 2), 5'd0,
            d[13:7], 1'b0, d[5:4], 2'b11, c};
  endfunction

  function automatic logic [31:0] exp_phy(input int gen, input logic [31:0] d);
    if (gen == 1) return d;
    if (gen == 2) return {d[31:1], 1'b0};
    return {d[31:5], 1'b1, d[3:1], 1'b0};
  endfunction

  function automatic logic [31:0] exp_test(input int gen, input logic [31:0] d);
    if (gen == 1) return d;
    return {d[31:14], 2'b01, d[11:0]};
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    int          g;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    if (bus_valid && !bus_we) begin
      for (int k = 0; k < NG; k++) begin
        item_t it;
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty: actual=%08h expected=none", rd[k]);
        end else begin
          it = sbq.pop_front();
          if (rd[it.g] !== it.exp) begin
            errors++;
            $display("FAIL %s gen%0d: actual=%08h expected=%08h",
                     it.tag, it.g + 1, rd[it.g], it.exp);
          end
        end
      end
    end
  end

  // ---------------- driver tasks (start and end 1 ns after an edge) ----------------
  task automatic rd_chk(input int idx, input string tag,
                        input logic [31:0] e0, input logic [31:0] e1, input logic [31:0] e2);
    sbq.push_back('{0, e0, tag});
    sbq.push_back('{1, e1, tag});
    sbq.push_back('{2, e2, tag});
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(idx);
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(idx); bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic err_chk(input logic e, input string tag);
    for (int k = 0; k < NG; k++) begin
      checks++;
      if (err[k] !== e) begin
        errors++;
        $display("FAIL %s lock_err gen%0d: actual=%0b expected=%0b", tag, k + 1, err[k], e);
      end
    end
  endtask

  task automatic cfg_rt(input logic [31:0] d, input string tag);
    wr(1, d);
    rd_chk(1, tag, exp_cfg(1, RAMS[0], d), exp_cfg(2, RAMS[1], d), exp_cfg(3, RAMS[2], d));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(0, "R1 lock", 0, 0, 0);
    rd_chk(1, "R1 cfg", exp_cfg(1, RAMS[0], 0), exp_cfg(2, RAMS[1], 0), exp_cfg(3, RAMS[2], 0));
    rd_chk(5, "R1 plain", 0, 0, 0);
    rd_chk(24, "R1 phy", 0, 0, 0);
    rd_chk(28, "R1 test", 0, 0, 0);
    err_chk(1'b0, "R1");

    // R3 locked writes are refused
    wr(5, 32'hDEAD_BEEF);
    err_chk(1'b1, "R3 pulse");
    rd_chk(5, "R3 plain held", 0, 0, 0);
    err_chk(1'b0, "R3 one cycle");
    wr(1, 32'hFFFF_FFFF);
    err_chk(1'b1, "R3 cfg pulse");
    rd_chk(1, "R3 cfg held", exp_cfg(1, RAMS[0], 0), exp_cfg(2, RAMS[1], 0), exp_cfg(3, RAMS[2], 0));

    // R10 out-of-range while locked: no pulse
    wr(40, 32'h1111_1111);
    err_chk(1'b0, "R10 locked range");

    // R2 wrong key then right key
    wr(0, 32'hFC60_0308);
    err_chk(1'b0, "R2 no pulse");
    rd_chk(0, "R2 wrong key", 0, 0, 0);
    wr(0, 32'hFC60_0309);
    rd_chk(0, "R2 right key", 1, 1, 1);

    // R9 plain registers, read right after write
    wr(5, 32'hDEAD_BEEF);
    rd_chk(5, "R9 plain", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    wr(31, 32'hA5A5_5A5A);
    rd_chk(31, "R9 top index", 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hA5A5_5A5A);

    // R10 out-of-range does not alias
    wr(8, 32'h2222_2222);
    wr(40, 32'h1111_1111);
    err_chk(1'b0, "R10 unlocked range");
    rd_chk(8, "R10 no alias", 32'h2222_2222, 32'h2222_2222, 32'h2222_2222);
    rd_chk(40, "R10 read zero", 0, 0, 0);
    rd_chk(1023, "R10 window end", 0, 0, 0);

    // R4 R5 R6 configuration masking
    cfg_rt(32'hFFFF_FFFF, "R4 R5 R6 cfg ones");
    cfg_rt(32'h0000_0000, "R4 R5 R6 cfg zeros");
    cfg_rt(32'h5555_AAAA, "R5 R6 cfg alt");
    cfg_rt(32'hAAAA_5555, "R5 R6 cfg alt2");

    // R7 PHY status
    wr(24, 32'hFFFF_FFFF);
    rd_chk(24, "R7 phy ones", exp_phy(1, 32'hFFFF_FFFF), exp_phy(2, 32'hFFFF_FFFF), exp_phy(3, 32'hFFFF_FFFF));
    wr(24, 32'h0000_0000);
    rd_chk(24, "R7 phy zeros", exp_phy(1, 0), exp_phy(2, 0), exp_phy(3, 0));

    // R8 self-test
    wr(28, 32'h0000_2000);
    rd_chk(28, "R8 test fail bit", exp_test(1, 32'h2000), exp_test(2, 32'h2000), exp_test(3, 32'h2000));
    wr(28, 32'h0000_0000);
    rd_chk(28, "R8 test zeros", exp_test(1, 0), exp_test(2, 0), exp_test(3, 0));

    // R2 R3 relock and confirm refusal
    wr(0, 32'h0);
    rd_chk(0, "R2 relock", 0, 0, 0);
    wr(5, 32'h0);
    err_chk(1'b1, "R3 relocked pulse");
    rd_chk(5, "R3 relocked held", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);

    @(posedge clk); #1;
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover: actual=%0d expected=0", sbq.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule